// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block forms data-memory addresses for a DSP core and keeps the state that addressing needs: a bank of auxiliary registers, a pointer that picks the current register, a backup copy of the previous pointer, a data page and a test flag. It operates on one operation per clock. A memory operation either builds a direct address from the page and a 7-bit offset in the instruction, or uses the current register as the address and then post-modifies that register. The post-modification can step by one or by an index value, and it can switch the pointer to another register.

Two circular buffers can each be tied to one register. When that register reaches the buffer's end address, the next step reloads the start address instead of stepping. Further operations load the page or a register, step the current register by an 8-bit constant, and compare the current register with a compare value to set the test flag. The address, its valid strobe and an illegal-mode strobe are registered and appear one cycle after the operation. Memory itself lies outside the block.

Top module: `auxreg_agu`

## Requirements
- R1: After reset all registers, the page, the pointer, the backup pointer and the test flag are 0, and `ea_vld` and `illegal` are 0.
- R2: `op_kind` codes: 0 and 7 do nothing, 1 memory access, 2 load page, 3 load register, 4 compare, 5 add constant, 6 subtract constant. Load page takes `instr[8:0]`; load register writes `ld_val` into register `instr[2:0]` with no circular rule.
- R3: A memory access with `instr[7]`=0 gives `ea` = (page << 7) | `instr[6:0]` with `ea_vld`=1 in the next cycle and changes no register or pointer.
- R4: A memory access with `instr[7]`=1 and a legal mode gives `ea` equal to the current register's value before the operation, with `ea_vld`=1 in the next cycle.
- R5: Mode `instr[6:3]`: 0 keeps the register, 2 subtracts 1, 4 adds 1, 0xA subtracts `index_val`, 0xC adds `index_val`, all modulo 2^16.
- R6: The odd modes 1, 3, 5, 0xB, 0xD apply the change of the even mode one below to the old current register, then copy the old pointer into `arb` and load `instr[2:0]` into `arp`.
- R7: `circ_ctrl[2:0]` picks the register of buffer 1 and `circ_ctrl[3]` enables it; `circ_ctrl[6:4]` and `circ_ctrl[7]` do the same for buffer 2. A stepped register tied to an enabled buffer that equals that buffer's end value is loaded with its start value instead.
- R8: When both buffers are enabled on the same register, buffer 1's start and end values apply.
- R9: Compare sets `tc` from an unsigned test of the current register against `cmp_val` by `instr[1:0]`: 0 equal, 1 less, 2 greater, 3 not equal.
- R10: Add and subtract constant step the current register by the zero-extended `instr[7:0]`, following the circular rule.
- R11: Indirect modes 6, 7, 8, 9, 0xE and 0xF pulse `illegal` in the next cycle, keep `ea_vld` at 0 and change no register or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation code |
| instr | input | 16 | Instruction word |
| ld_val | input | 16 | Value for load register |
| index_val | input | 16 | Index step |
| cmp_val | input | 16 | Compare value |
| circ_ctrl | input | 8 | Circular buffer selects and enables |
| circ_start1 | input | 16 | Buffer 1 start address |
| circ_end1 | input | 16 | Buffer 1 end address |
| circ_start2 | input | 16 | Buffer 2 start address |
| circ_end2 | input | 16 | Buffer 2 end address |
| ea | output | 16 | Effective address |
| ea_vld | output | 1 | Address valid strobe |
| illegal | output | 1 | Illegal mode strobe |
| arp | output | 3 | Current register pointer |
| arb | output | 3 | Backup pointer |
| tc | output | 1 | Test flag |
| ar_all | output | 128 | All registers, register k in bits 16k+15:16k |

## Verification
The bench builds the block with its defaults: eight 16-bit registers and both circular buffers present. With two buffers, both the priority case with the two buffers on one register and the case where only buffer 2 matches can be reached. Random traffic often sets a buffer's end value to the present contents of its register, so wraps happen often and are mixed with pointer switches and index steps.

// File: rtl/auxreg_agu_pkg.sv
package auxreg_agu_pkg;

   typedef enum logic [2:0] {
      K_NOP  = 3'd0,
      K_MEM  = 3'd1,
      K_LDP  = 3'd2,
      K_LDAR = 3'd3,
      K_CMP  = 3'd4,
      K_ADDK = 3'd5,
      K_SUBK = 3'd6,
      K_RSVD = 3'd7
   } op_kind_e;

   typedef enum logic [2:0] {
      ST_NONE = 3'd0,
      ST_DEC  = 3'd1,
      ST_INC  = 3'd2,
      ST_SUBX = 3'd3,
      ST_ADDX = 3'd4
   } step_e;

   typedef struct packed {
      step_e step;
      logic  swap;
      logic  bad;
   } mode_t;

endpackage

// File: rtl/auxreg_mode_dec.sv
module auxreg_mode_dec
   import auxreg_agu_pkg::*;
(
   input  logic [3:0] code,
   output mode_t      mode
);
   always_comb begin
      mode.swap = code[0];
      mode.bad  = 1'b0;
      unique case (code[3:1])
         3'd0:    mode.step = ST_NONE;
         3'd1:    mode.step = ST_DEC;
         3'd2:    mode.step = ST_INC;
         3'd5:    mode.step = ST_SUBX;
         3'd6:    mode.step = ST_ADDX;
         default: begin
            mode.step = ST_NONE;
            mode.bad  = 1'b1;
            mode.swap = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/auxreg_circ_step.sv
module auxreg_circ_step #(
   parameter int AR_W   = 16,
   parameter int PTR_W  = 3,
   parameter int N_CIRC = 2,
   localparam int CTRL_W = 2 * (PTR_W + 1)
) (
   input  logic [AR_W-1:0]   cur,
   input  logic [PTR_W-1:0]  idx,
   input  logic [AR_W-1:0]   delta,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [AR_W-1:0]   start1,
   input  logic [AR_W-1:0]   end1,
   input  logic [AR_W-1:0]   start2,
   input  logic [AR_W-1:0]   end2,
   output logic [AR_W-1:0]   nxt
);
   logic [AR_W-1:0] plain;
   logic            hit1, hit2;

   initial begin
      assert (N_CIRC >= 0 && N_CIRC <= 2)
         else $fatal(1, "N_CIRC must be 0, 1 or 2");
   end

   assign plain = cur + delta;

   generate
      if (N_CIRC >= 1) begin : g_buf1
         assign hit1 = ctrl[PTR_W] && (ctrl[PTR_W-1:0] == idx);
      end else begin : g_nobuf1
         assign hit1 = 1'b0;
      end
      if (N_CIRC >= 2) begin : g_buf2
         assign hit2 = ctrl[2*PTR_W+1] && (ctrl[2*PTR_W:PTR_W+1] == idx);
      end else begin : g_nobuf2
         assign hit2 = 1'b0;
      end
   endgenerate

   always_comb begin
      if (hit1)
         nxt = (cur == end1) ? start1 : plain;
      else if (hit2)
         nxt = (cur == end2) ? start2 : plain;
      else
         nxt = plain;
   end
endmodule

// File: rtl/auxreg_bank.sv
module auxreg_bank #(
   parameter int AR_W = 16,
   parameter int AR_N = 8,
   localparam int PTR_W = $clog2(AR_N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [PTR_W-1:0]     waddr,
   input  logic [AR_W-1:0]      wdata,
   input  logic [PTR_W-1:0]     raddr,
   output logic [AR_W-1:0]      rdata,
   output logic [AR_N*AR_W-1:0] flat
);
   generate
      for (genvar i = 0; i < AR_N; i++) begin : g_reg
         logic [AR_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (we && (waddr == PTR_W'(i)))
               q <= wdata;
         end
         assign flat[i*AR_W +: AR_W] = q;
      end
   endgenerate

   assign rdata = flat[raddr*AR_W +: AR_W];
endmodule

// File: rtl/auxreg_agu.sv
module auxreg_agu
   import auxreg_agu_pkg::*;
#(
   parameter int AR_W   = 16,
   parameter int AR_N   = 8,
   parameter int OFS_W  = 7,
   parameter int PAGE_W = 9,
   parameter int IMM_W  = 8,
   parameter int N_CIRC = 2,
   localparam int PTR_W  = $clog2(AR_N),
   localparam int CTRL_W = 2 * (PTR_W + 1),
   localparam int ALL_W  = AR_N * AR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_vld,
   input  logic [2:0]        op_kind,
   input  logic [15:0]       instr,
   input  logic [AR_W-1:0]   ld_val,
   input  logic [AR_W-1:0]   index_val,
   input  logic [AR_W-1:0]   cmp_val,
   input  logic [CTRL_W-1:0] circ_ctrl,
   input  logic [AR_W-1:0]   circ_start1,
   input  logic [AR_W-1:0]   circ_end1,
   input  logic [AR_W-1:0]   circ_start2,
   input  logic [AR_W-1:0]   circ_end2,
   output logic [AR_W-1:0]   ea,
   output logic              ea_vld,
   output logic              illegal,
   output logic [PTR_W-1:0]  arp,
   output logic [PTR_W-1:0]  arb,
   output logic              tc,
   output logic [ALL_W-1:0]  ar_all
);
   initial begin
      assert (AR_N == (1 << PTR_W)) else $fatal(1, "AR_N must be a power of two");
      assert (AR_W == PAGE_W + OFS_W) else $fatal(1, "AR_W must equal PAGE_W + OFS_W");
      assert (PTR_W == 3) else $fatal(1, "instruction fields assume eight registers");
      assert (OFS_W == 7 && IMM_W <= AR_W) else $fatal(1, "offset or constant width");
   end

   op_kind_e         kind;
   mode_t            mode;
   logic [AR_W-1:0]  cur_ar, delta, step_nxt;
   logic [AR_W-1:0]  imm_ext;
   logic             is_mem, is_ind, mode_ok, step_go, wr_en;
   logic [PTR_W-1:0] wr_idx;
   logic [AR_W-1:0]  wr_val;
   logic [PAGE_W-1:0] page_q;
   logic [AR_W-1:0]  ea_q;
   logic             ea_vld_q, ill_q, tc_q;
   logic [PTR_W-1:0] arp_q, arb_q;

   assign kind    = op_kind_e'(op_kind);
   assign is_mem  = op_vld && (kind == K_MEM);
   assign is_ind  = instr[7];
   assign mode_ok = !mode.bad;
   assign imm_ext = AR_W'(instr[IMM_W-1:0]);

   auxreg_mode_dec u_dec (
      .code (instr[6:3]),
      .mode (mode)
   );

   always_comb begin
      delta   = '0;
      step_go = 1'b0;
      if (is_mem && is_ind && mode_ok) begin
         step_go = (mode.step != ST_NONE);
         unique case (mode.step)
            ST_DEC:  delta = '1;
            ST_INC:  delta = AR_W'(1);
            ST_SUBX: delta = '0 - index_val;
            ST_ADDX: delta = index_val;
            default: delta = '0;
         endcase
      end else if (op_vld && kind == K_ADDK) begin
         step_go = 1'b1;
         delta   = imm_ext;
      end else if (op_vld && kind == K_SUBK) begin
         step_go = 1'b1;
         delta   = '0 - imm_ext;
      end
   end

   auxreg_circ_step #(
      .AR_W   (AR_W),
      .PTR_W  (PTR_W),
      .N_CIRC (N_CIRC)
   ) u_step (
      .cur    (cur_ar),
      .idx    (arp_q),
      .delta  (delta),
      .ctrl   (circ_ctrl),
      .start1 (circ_start1),
      .end1   (circ_end1),
      .start2 (circ_start2),
      .end2   (circ_end2),
      .nxt    (step_nxt)
   );

   always_comb begin
      wr_en  = step_go;
      wr_idx = arp_q;
      wr_val = step_nxt;
      if (op_vld && kind == K_LDAR) begin
         wr_en  = 1'b1;
         wr_idx = instr[PTR_W-1:0];
         wr_val = ld_val;
      end
   end

   auxreg_bank #(
      .AR_W (AR_W),
      .AR_N (AR_N)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_idx),
      .wdata (wr_val),
      .raddr (arp_q),
      .rdata (cur_ar),
      .flat  (ar_all)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arp_q    <= '0;
         arb_q    <= '0;
         page_q   <= '0;
         tc_q     <= 1'b0;
         ea_q     <= '0;
         ea_vld_q <= 1'b0;
         ill_q    <= 1'b0;
      end else begin
         ea_vld_q <= 1'b0;
         ill_q    <= 1'b0;
         if (is_mem) begin
            if (!is_ind) begin
               ea_q     <= {page_q, {OFS_W{1'b0}}} | AR_W'(instr[OFS_W-1:0]);
               ea_vld_q <= 1'b1;
            end else if (mode_ok) begin
               ea_q     <= cur_ar;
               ea_vld_q <= 1'b1;
               if (mode.swap) begin
                  arb_q <= arp_q;
                  arp_q <= instr[PTR_W-1:0];
               end
            end else begin
               ill_q <= 1'b1;
            end
         end
         if (op_vld && kind == K_LDP)
            page_q <= instr[PAGE_W-1:0];
         if (op_vld && kind == K_CMP) begin
            unique case (instr[1:0])
               2'd0: tc_q <= (cur_ar == cmp_val);
               2'd1: tc_q <= (cur_ar <  cmp_val);
               2'd2: tc_q <= (cur_ar >  cmp_val);
               default: tc_q <= (cur_ar != cmp_val);
            endcase
         end
      end
   end

   assign ea      = ea_q;
   assign ea_vld  = ea_vld_q;
   assign illegal = ill_q;
   assign arp     = arp_q;
   assign arb     = arb_q;
   assign tc      = tc_q;

   // R4
   ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mem && is_ind && mode_ok) |=> (ea_vld && ea == $past(cur_ar)));

   // R6
   ptr_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mem && is_ind && mode_ok && mode.swap)
         |=> (arb == $past(arp) && arp == $past(instr[PTR_W-1:0])));

   // R11
   bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mem && is_ind && mode.bad)
         |=> (illegal && !ea_vld && $stable(ar_all) && $stable(arp) && $stable(arb)));

   // R3
   direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mem && !is_ind) |=> (ea_vld && $stable(ar_all) && $stable(arp)));

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ea_vld && illegal));

   generate
      if (N_CIRC >= 1) begin : g_wrap_chk
         // R7
         circ_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_vld && kind == K_ADDK && circ_ctrl[PTR_W] &&
             circ_ctrl[PTR_W-1:0] == arp && cur_ar == circ_end1)
               |=> (cur_ar == $past(circ_start1)));
      end
   endgenerate
endmodule

// File: tb/auxreg_agu_tb.sv
module auxreg_agu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_vld = 1'b0;
   logic [2:0]  op_kind = '0;
   logic [15:0] instr = '0, ld_val = '0, index_val = '0, cmp_val = '0;
   logic [7:0]  circ_ctrl = '0;
   logic [15:0] circ_start1 = '0, circ_end1 = '0, circ_start2 = '0, circ_end2 = '0;
   logic [15:0] ea;
   logic        ea_vld, illegal, tc;
   logic [2:0]  arp, arb;
   logic [127:0] ar_all;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_ar [8];
   logic [2:0]  m_arp, m_arb;
   logic [8:0]  m_page;
   logic        m_tc;
   logic [15:0] x_ea;
   logic        x_eav, x_ill;

   auxreg_agu u_dut (
      .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_kind(op_kind), .instr(instr),
      .ld_val(ld_val), .index_val(index_val), .cmp_val(cmp_val), .circ_ctrl(circ_ctrl),
      .circ_start1(circ_start1), .circ_end1(circ_end1),
      .circ_start2(circ_start2), .circ_end2(circ_end2),
      .ea(ea), .ea_vld(ea_vld), .illegal(illegal), .arp(arp), .arb(arb), .tc(tc),
      .ar_all(ar_all)
   );

   always #10 clk = ~clk;

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] cnext(input logic [2:0] idx, input logic [15:0] cur,
                                         input logic [15:0] d);
      if (circ_ctrl[3] && circ_ctrl[2:0] == idx)
         return (cur == circ_end1) ? circ_start1 : cur + d;
      if (circ_ctrl[7] && circ_ctrl[6:4] == idx)
         return (cur == circ_end2) ? circ_start2 : cur + d;
      return cur + d;
   endfunction

   function automatic bit code_bad(input logic [3:0] c);
      return (c == 4'd6 || c == 4'd7 || c == 4'd8 || c == 4'd9 || c == 4'd14 || c == 4'd15);
   endfunction

   task automatic check_all(input string tag);
      chk(tag, "ea_vld", 32'(ea_vld), 32'(x_eav));
      chk(tag, "illegal", 32'(illegal), 32'(x_ill));
      if (x_eav) chk(tag, "ea", 32'(ea), 32'(x_ea));
      chk(tag, "arp", 32'(arp), 32'(m_arp));
      chk(tag, "arb", 32'(arb), 32'(m_arb));
      chk(tag, "tc", 32'(tc), 32'(m_tc));
      for (int k = 0; k < 8; k++)
         chk(tag, "reg", 32'(ar_all[k*16 +: 16]), 32'(m_ar[k]));
   endtask

   task automatic do_op(input logic [2:0] kind, input logic [15:0] iw,
                        input logic [15:0] lv, input string tag);
      logic [15:0] cur;
      logic [15:0] d;
      @(negedge clk);
      op_vld = 1'b1; op_kind = kind; instr = iw; ld_val = lv;
      x_eav = 1'b0; x_ill = 1'b0; x_ea = '0;
      cur = m_ar[m_arp];
      case (kind)
         3'd1: begin
            if (!iw[7]) begin
               x_eav = 1'b1;
               x_ea  = {m_page, 7'b0} | {9'b0, iw[6:0]};
            end else if (code_bad(iw[6:3])) begin
               x_ill = 1'b1;
            end else begin
               x_eav = 1'b1;
               x_ea  = cur;
               case (iw[6:4])
                  3'd1: d = 16'hFFFF;
                  3'd2: d = 16'd1;
                  3'd5: d = 16'd0 - index_val;
                  3'd6: d = index_val;
                  default: d = 16'd0;
               endcase
               if (iw[6:4] != 3'd0) m_ar[m_arp] = cnext(m_arp, cur, d);
               if (iw[3]) begin
                  m_arb = m_arp;
                  m_arp = iw[2:0];
               end
            end
         end
         3'd2: m_page = iw[8:0];
         3'd3: m_ar[iw[2:0]] = lv;
         3'd4: case (iw[1:0])
                  2'd0: m_tc = (cur == cmp_val);
                  2'd1: m_tc = (cur < cmp_val);
                  2'd2: m_tc = (cur > cmp_val);
                  default: m_tc = (cur != cmp_val);
               endcase
         3'd5: m_ar[m_arp] = cnext(m_arp, cur, {8'b0, iw[7:0]});
         3'd6: m_ar[m_arp] = cnext(m_arp, cur, 16'd0 - {8'b0, iw[7:0]});
         default: ;
      endcase
      @(negedge clk);
      op_vld = 1'b0;
      check_all(tag);
   endtask

   function automatic logic [15:0] ind(input logic [3:0] code, input logic [2:0] nar);
      return {8'h00, 1'b1, code, nar};
   endfunction

   initial begin
      int seed;
      for (int k = 0; k < 8; k++) m_ar[k] = '0;
      m_arp = '0; m_arb = '0; m_page = '0; m_tc = 1'b0;
      x_eav = 1'b0; x_ill = 1'b0; x_ea = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2, R3: page load then direct access
      do_op(3'd2, 16'h01A5, 16'h0, "R2");
      do_op(3'd1, 16'h005B, 16'h0, "R3");
      do_op(3'd7, 16'hFFFF, 16'h1234, "R2");
      // R2 load registers
      for (int k = 0; k < 8; k++) do_op(3'd3, 16'(k), 16'(16'h1000 + k * 16'h111), "R2");
      // R4, R5 step modes
      index_val = 16'h0040;
      do_op(3'd1, ind(4'h0, 3'd0), 16'h0, "R4");
      do_op(3'd1, ind(4'h2, 3'd0), 16'h0, "R5");
      do_op(3'd1, ind(4'h4, 3'd0), 16'h0, "R5");
      do_op(3'd1, ind(4'hA, 3'd0), 16'h0, "R5");
      do_op(3'd1, ind(4'hC, 3'd0), 16'h0, "R5");
      // R6 pointer switch
      do_op(3'd1, ind(4'h5, 3'd3), 16'h0, "R6");
      do_op(3'd1, ind(4'hB, 3'd6), 16'h0, "R6");
      do_op(3'd1, ind(4'h1, 3'd2), 16'h0, "R6");
      // R11 illegal codes
      do_op(3'd1, ind(4'h6, 3'd5), 16'h0, "R11");
      do_op(3'd1, ind(4'h9, 3'd5), 16'h0, "R11");
      do_op(3'd1, ind(4'hF, 3'd1), 16'h0, "R11");
      // R7 buffer 2 wrap on register 2
      do_op(3'd3, 16'h0002, 16'h2000, "R2");
      circ_ctrl = 8'hA0; circ_start2 = 16'h1F00; circ_end2 = 16'h2000;
      do_op(3'd1, ind(4'h4, 3'd2), 16'h0, "R7");
      do_op(3'd1, ind(4'h4, 3'd2), 16'h0, "R7");
      // R8 both buffers on register 2
      circ_ctrl = 8'hAA; circ_start1 = 16'h0300; circ_end1 = 16'h1F01;
      circ_end2 = 16'h1F01;
      do_op(3'd1, ind(4'h2, 3'd2), 16'h0, "R8");
      // R10 constant steps with wrap
      do_op(3'd5, 16'h00FF, 16'h0, "R10");
      do_op(3'd6, 16'h0010, 16'h0, "R10");
      do_op(3'd3, 16'h0002, 16'h1F01, "R2");
      do_op(3'd5, 16'h0004, 16'h0, "R10");
      // R9 compare codes
      cmp_val = 16'h0300;
      for (int c = 0; c < 4; c++) do_op(3'd4, 16'(c), 16'h0, "R9");
      cmp_val = 16'h0400;
      for (int c = 0; c < 4; c++) do_op(3'd4, 16'(c), 16'h0, "R9");
      cmp_val = 16'h0100;
      for (int c = 0; c < 4; c++) do_op(3'd4, 16'(c), 16'h0, "R9");

      // random traffic
      seed = $urandom(32'h5EED_1234);
      for (int n = 0; n < 4000; n++) begin
         logic [2:0]  kd;
         logic [15:0] iw;
         string       tg;
         if (n % 64 == 0) begin
            circ_ctrl   = 8'($urandom);
            circ_start1 = 16'($urandom);
            circ_start2 = 16'($urandom);
            index_val   = 16'($urandom);
            cmp_val     = 16'($urandom);
         end
         circ_end1 = ($urandom % 3 == 0) ? m_ar[circ_ctrl[2:0]] : 16'($urandom);
         circ_end2 = ($urandom % 3 == 0) ? m_ar[circ_ctrl[6:4]] : 16'($urandom);
         if ($urandom % 4 == 0) cmp_val = m_ar[m_arp];
         kd = 3'($urandom % 8);
         if ($urandom % 2 == 0) kd = 3'd1;
         iw = 16'($urandom);
         case (kd)
            3'd1: tg = iw[7] ? (code_bad(iw[6:3]) ? "R11" : "R5") : "R3";
            3'd4: tg = "R9";
            3'd5, 3'd6: tg = "R10";
            default: tg = "R2";
         endcase
         do_op(kd, iw, 16'($urandom), tg);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule